// File: doc/BRIEF.md
# Line and Framer Interrupt Status Collector

This block turns framer and transmit-line conditions into an 8-bit interrupt status word that software clears by reading it. Some inputs are levels: loss of frame alignment, loss of multiframe alignment, transmit line open, transmit line short, and alarm simulation active. The block watches these for particular edges. Other inputs are one-cycle pulses: transmit multiframe begin, transmit pool ready, and transmit underrun. Each qualifying event sets a sticky status bit. A read strobe returns the word and clears it in one step.

A per-bit mask keeps events off the active-high interrupt pin and off the summary bit that feeds a global status register. A control input decides whether a masked event is recorded at all. If it is 1, the event is latched and can be read, but it still never reaches the pin or the summary. If it is 0, the event is dropped.

A transmit underrun raises a transmitter-disable flag. The flag stays high until the status word is read.

Top module: `line_irq_status`

## Requirements
- R1: After reset, rd_data_o, irq_o, summary_o and tx_disable_o are all 0. The level history is also 0, so a level input that is high in the first cycle after reset counts as a rising edge.
- R2: Status bit layout: 7 alignment regained, 6 alignment lost, 5 multiframe alignment regained, 4 multiframe alignment lost, 3 multiframe begin, 2 line status change, 1 pool ready. rd_data_o always shows the stored word. A cycle with rd_en_i high clears every bit at the following clock edge.
- R3: An event that occurs in the same cycle as rd_en_i is stored after the clear, so it is visible in the next cycle.
- R4: Bit 2 sets on a rising edge of tx_open_i and on any change of tx_short_i. A falling edge of tx_open_i does not set it.
- R5: Bit 7 sets on a falling edge of lof_i. It also sets on a falling edge of alm_sim_i while lof_i is low in that cycle.
- R6: Bit 6 sets on a rising edge of lof_i, and in every cycle in which alm_sim_i is high.
- R7: Bit 5 sets on a falling edge of lomf_i, and bit 4 sets on a rising edge of lomf_i.
- R8: A one-cycle pulse on mf_begin_i sets bit 3, and a one-cycle pulse on pool_ready_i sets bit 1.
- R9: With vis_masked_i at 0, an event whose mask_i bit (same position as the status bit, 1 = masked) is 1 does not set its status bit.
- R10: With vis_masked_i at 1, a masked event sets its status bit, but that bit holds irq_o and summary_o low.
- R11: irq_o and summary_o are both the OR of the stored bits whose mask bit is 0. They follow mask_i in the same cycle.
- R12: An underrun_i pulse raises tx_disable_o in the next cycle. tx_disable_o then holds until the clock edge after a read. An underrun in the read cycle keeps it high.
- R13: Bit 0 is reserved and always reads 0. Its mask bit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lof_i | input | 1 | Loss of frame alignment level |
| lomf_i | input | 1 | Loss of multiframe alignment level |
| tx_open_i | input | 1 | Transmit line open level |
| tx_short_i | input | 1 | Transmit line short level |
| alm_sim_i | input | 1 | Alarm simulation active level |
| mf_begin_i | input | 1 | Transmit multiframe begin pulse |
| pool_ready_i | input | 1 | Transmit pool ready pulse |
| underrun_i | input | 1 | Transmit underrun pulse |
| mask_i | input | 8 | Per-bit interrupt mask, 1 = masked |
| vis_masked_i | input | 1 | 1 = record masked events |
| rd_en_i | input | 1 | Status read strobe |
| rd_data_o | output | 8 | Stored status word |
| irq_o | output | 1 | Active-high interrupt |
| summary_o | output | 1 | Summary bit for global status |
| tx_disable_o | output | 1 | Transmitter held off after underrun |

## Verification
The properties assume the pulse inputs are already one cycle wide. They also assume the level inputs are synchronous to clk, so each edge is seen exactly once. The stimulus drives every input on the falling clock edge and holds all levels low through reset, which keeps the reset-time level history consistent with the first sampled values. Directed phases toggle each level on its own, with and without a coincident read. Random phases cover mask and visibility combinations that the directed phases cannot list in full.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
   localparam int unsigned ST_W   = 8;
   localparam int unsigned B_FAR  = 7;
   localparam int unsigned B_LFA  = 6;
   localparam int unsigned B_MFAR = 5;
   localparam int unsigned B_LMFA = 4;
   localparam int unsigned B_XMB  = 3;
   localparam int unsigned B_XLSC = 2;
   localparam int unsigned B_XPR  = 1;
   localparam int unsigned B_RSVD = 0;

   typedef struct packed {
      logic lof;
      logic lomf;
      logic open;
      logic short_l;
      logic alm;
   } levels_t;
endpackage

// File: rtl/lirq_event_gen.sv
module lirq_event_gen
   import lirq_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  levels_t         lv,
   input  logic            mf_begin,
   input  logic            pool_ready,
   output logic [ST_W-1:0] evt
);
   levels_t prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lv;
   end

   always_comb begin
      evt         = '0;
      evt[B_FAR]  = (prev_q.lof & ~lv.lof) | (prev_q.alm & ~lv.alm & ~lv.lof);
      evt[B_LFA]  = (lv.lof & ~prev_q.lof) | lv.alm;
      evt[B_MFAR] = prev_q.lomf & ~lv.lomf;
      evt[B_LMFA] = lv.lomf & ~prev_q.lomf;
      evt[B_XMB]  = mf_begin;
      evt[B_XLSC] = (lv.open & ~prev_q.open) | (lv.short_l ^ prev_q.short_l);
      evt[B_XPR]  = pool_ready;
   end
endmodule

// File: rtl/lirq_status_reg.sv
module lirq_status_reg #(
   parameter int unsigned     W         = 8,
   parameter logic [W-1:0]    RSVD_BITS = 8'h01
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic [W-1:0] mask,
   input  logic         vis_masked,
   input  logic         rd_en,
   output logic [W-1:0] status
);
   logic [W-1:0] admit;

   assign admit = evt & (vis_masked ? {W{1'b1}} : ~mask);

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (RSVD_BITS[i]) begin : g_rsvd
         assign status[i] = 1'b0;
      end else begin : g_live
         logic bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= (bit_q & ~rd_en) | admit[i];
         end
         assign status[i] = bit_q;
      end
   end
endmodule

// File: rtl/lirq_txdis.sv
module lirq_txdis (
   input  logic clk,
   input  logic rst_n,
   input  logic underrun,
   input  logic rd_en,
   output logic tx_disable
);
   logic dis_q;

   always_ff @(posedge clk) begin
      if (!rst_n) dis_q <= 1'b0;
      else        dis_q <= underrun | (dis_q & ~rd_en);
   end

   assign tx_disable = dis_q;
endmodule

// File: rtl/lirq_irq_out.sv
module lirq_irq_out #(
   parameter int unsigned  W         = 8,
   parameter logic [W-1:0] RSVD_BITS = 8'h01,
   parameter bit           REG_OUT   = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] status,
   input  logic [W-1:0] mask,
   output logic         irq,
   output logic         summary
);
   logic pend;

   assign pend = |(status & ~mask & ~RSVD_BITS);

   if (REG_OUT) begin : g_reg
      logic pend_q;
      always_ff @(posedge clk) begin
         if (!rst_n) pend_q <= 1'b0;
         else        pend_q <= pend;
      end
      assign irq     = pend_q;
      assign summary = pend_q;
   end else begin : g_comb
      assign irq     = pend;
      assign summary = pend;
   end
endmodule

// File: rtl/line_irq_status.sv
module line_irq_status
   import lirq_pkg::*;
#(
   parameter int unsigned         STATUS_W       = 8,
   parameter logic [STATUS_W-1:0] RSVD_BITS      = 8'h01,
   parameter bit                  IRQ_REGISTERED = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lof_i,
   input  logic                lomf_i,
   input  logic                tx_open_i,
   input  logic                tx_short_i,
   input  logic                alm_sim_i,
   input  logic                mf_begin_i,
   input  logic                pool_ready_i,
   input  logic                underrun_i,
   input  logic [STATUS_W-1:0] mask_i,
   input  logic                vis_masked_i,
   input  logic                rd_en_i,
   output logic [STATUS_W-1:0] rd_data_o,
   output logic                irq_o,
   output logic                summary_o,
   output logic                tx_disable_o
);
   if (STATUS_W != ST_W) begin : g_bad_width
      $error("line_irq_status: STATUS_W must equal the fixed bit layout width");
   end
   if (RSVD_BITS[B_RSVD] != 1'b1) begin : g_bad_rsvd
      $error("line_irq_status: reserved bit must be marked in RSVD_BITS");
   end

   levels_t          lv;
   logic [ST_W-1:0]  evt;

   assign lv.lof     = lof_i;
   assign lv.lomf    = lomf_i;
   assign lv.open    = tx_open_i;
   assign lv.short_l = tx_short_i;
   assign lv.alm     = alm_sim_i;

   lirq_event_gen u_evt (
      .clk        (clk),
      .rst_n      (rst_n),
      .lv         (lv),
      .mf_begin   (mf_begin_i),
      .pool_ready (pool_ready_i),
      .evt        (evt)
   );

   lirq_status_reg #(.W(STATUS_W), .RSVD_BITS(RSVD_BITS)) u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (evt),
      .mask       (mask_i),
      .vis_masked (vis_masked_i),
      .rd_en      (rd_en_i),
      .status     (rd_data_o)
   );

   lirq_irq_out #(.W(STATUS_W), .RSVD_BITS(RSVD_BITS), .REG_OUT(IRQ_REGISTERED)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .status  (rd_data_o),
      .mask    (mask_i),
      .irq     (irq_o),
      .summary (summary_o)
   );

   lirq_txdis u_txdis (
      .clk        (clk),
      .rst_n      (rst_n),
      .underrun   (underrun_i),
      .rd_en      (rd_en_i),
      .tx_disable (tx_disable_o)
   );
endmodule

// File: rtl/lirq_checker.sv
module lirq_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] evt,
   input logic [7:0] status,
   input logic [7:0] mask,
   input logic       vis_masked,
   input logic       rd_en,
   input logic       alm_sim,
   input logic       underrun,
   input logic       tx_disable
);
   assert_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (evt == 8'h00)) |=> (status == 8'h00));

   assert_alm_sets_lfa_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (alm_sim && (vis_masked || !mask[6])) |=> status[6]);

   assert_masked_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !vis_masked |=> ((status & ~$past(status) & $past(mask)) == 8'h00));

   assert_txdis_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> tx_disable);

   assert_txdis_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_disable && !rd_en) |=> tx_disable);

   assert_txdis_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_disable && rd_en && !underrun) |=> !tx_disable);
endmodule

bind line_irq_status lirq_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .evt        (evt),
   .status     (rd_data_o),
   .mask       (mask_i),
   .vis_masked (vis_masked_i),
   .rd_en      (rd_en_i),
   .alm_sim    (alm_sim_i),
   .underrun   (underrun_i),
   .tx_disable (tx_disable_o)
);

// File: tb/tb_line_irq_status.sv
module tb_line_irq_status;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lof_i = 0, lomf_i = 0, tx_open_i = 0, tx_short_i = 0, alm_sim_i = 0;
   logic       mf_begin_i = 0, pool_ready_i = 0, underrun_i = 0;
   logic [7:0] mask_i = 8'h00;
   logic       vis_masked_i = 0, rd_en_i = 0;
   logic [7:0] rd_data_o;
   logic       irq_o, summary_o, tx_disable_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // reference model state
   bit [7:0] m_st = 0;
   bit       m_dis = 0;
   bit       p_lof = 0, p_lomf = 0, p_open = 0, p_short = 0, p_alm = 0;
   string    tag_prev = "R1";

   // stimulus for the next cycle
   bit s_lof = 0, s_lomf = 0, s_open = 0, s_short = 0, s_alm = 0;
   bit s_mf = 0, s_pr = 0, s_und = 0, s_vis = 0, s_rd = 0;
   bit [7:0] s_mask = 0;

   always #2 clk = ~clk;

   line_irq_status dut (
      .clk(clk), .rst_n(rst_n), .lof_i(lof_i), .lomf_i(lomf_i),
      .tx_open_i(tx_open_i), .tx_short_i(tx_short_i), .alm_sim_i(alm_sim_i),
      .mf_begin_i(mf_begin_i), .pool_ready_i(pool_ready_i), .underrun_i(underrun_i),
      .mask_i(mask_i), .vis_masked_i(vis_masked_i), .rd_en_i(rd_en_i),
      .rd_data_o(rd_data_o), .irq_o(irq_o), .summary_o(summary_o),
      .tx_disable_o(tx_disable_o)
   );

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         checks++;
         errors++;
         $display("FAIL watchdog (all requirements): run hung, actual %0d cycles expected < 100000", cycles);
         finish_run();
      end
   end

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp, string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic compare_outputs(string tag);
      bit pend;
      pend = |(m_st & ~mask_i & 8'hFE);
      chk(tag, rd_data_o, m_st, "status word");
      chk("R13", {7'd0, rd_data_o[0]}, 8'h00, "reserved bit");
      chk("R11", {7'd0, irq_o}, {7'd0, pend}, "irq");
      chk("R11", {7'd0, summary_o}, {7'd0, pend}, "summary");
      chk("R12", {7'd0, tx_disable_o}, {7'd0, m_dis}, "tx disable");
   endtask

   // one cycle: check what the last cycle produced, then apply new stimulus
   task automatic tick(string tag);
      bit [7:0] ev;
      @(negedge clk);
      compare_outputs(tag_prev);
      ev = 0;
      if ((p_lof && !s_lof) || (p_alm && !s_alm && !s_lof)) ev[7] = 1;
      if ((s_lof && !p_lof) || s_alm) ev[6] = 1;
      if (p_lomf && !s_lomf) ev[5] = 1;
      if (s_lomf && !p_lomf) ev[4] = 1;
      if (s_mf) ev[3] = 1;
      if ((s_open && !p_open) || (s_short != p_short)) ev[2] = 1;
      if (s_pr) ev[1] = 1;
      if (!s_vis) ev = ev & ~s_mask;
      m_st  = (s_rd ? 8'h00 : m_st) | ev;
      m_st[0] = 0;
      m_dis = s_und || (m_dis && !s_rd);
      p_lof = s_lof; p_lomf = s_lomf; p_open = s_open; p_short = s_short; p_alm = s_alm;
      lof_i = s_lof; lomf_i = s_lomf; tx_open_i = s_open; tx_short_i = s_short;
      alm_sim_i = s_alm; mf_begin_i = s_mf; pool_ready_i = s_pr; underrun_i = s_und;
      mask_i = s_mask; vis_masked_i = s_vis; rd_en_i = s_rd;
      tag_prev = tag;
   endtask

   task automatic quiet(int n, string tag);
      s_mf = 0; s_pr = 0; s_und = 0; s_rd = 0;
      for (int i = 0; i < n; i++) tick(tag);
   endtask

   task automatic do_read(string tag);
      s_rd = 1; tick(tag); s_rd = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      quiet(2, "R1");

      // R2 / R8: pulses then read clears
      s_mf = 1; tick("R8"); s_mf = 0;
      s_pr = 1; tick("R8"); s_pr = 0;
      quiet(1, "R8");
      do_read("R2");
      quiet(2, "R2");

      // R6 / R5: loss and regain of frame alignment
      s_lof = 1; tick("R6"); quiet(2, "R6"); do_read("R6");
      s_lof = 0; tick("R5"); quiet(1, "R5"); do_read("R5");
      // alarm simulation with receiver in sync, then ending -> regain bit
      s_alm = 1; tick("R6"); quiet(2, "R6"); do_read("R6");
      s_alm = 0; tick("R5"); quiet(1, "R5"); do_read("R5");
      // alarm ends while alignment lost -> no regain bit
      s_lof = 1; s_alm = 1; tick("R5"); do_read("R5");
      s_alm = 0; tick("R5"); quiet(1, "R5"); do_read("R5");
      s_lof = 0; tick("R5"); do_read("R5");

      // R7 multiframe alignment
      s_lomf = 1; tick("R7"); quiet(1, "R7"); do_read("R7");
      s_lomf = 0; tick("R7"); quiet(1, "R7"); do_read("R7");

      // R4 line status change
      s_open = 1; tick("R4"); do_read("R4");
      s_open = 0; tick("R4"); quiet(1, "R4");
      s_short = 1; tick("R4"); do_read("R4");
      s_short = 0; tick("R4"); quiet(1, "R4"); do_read("R4");

      // R3: event in the read cycle survives
      s_mf = 1; tick("R3"); s_mf = 0;
      s_pr = 1; s_rd = 1; tick("R3"); s_pr = 0; s_rd = 0;
      quiet(2, "R3"); do_read("R3");

      // R9: masked and not visible
      s_mask = 8'hFF; s_vis = 0;
      s_mf = 1; s_pr = 1; tick("R9"); s_mf = 0; s_pr = 0;
      s_lof = 1; tick("R9"); quiet(2, "R9");
      s_lof = 0; tick("R9"); quiet(1, "R9");

      // R10: masked but visible, no interrupt
      s_vis = 1;
      s_mf = 1; tick("R10"); s_mf = 0;
      s_short = 1; tick("R10"); quiet(2, "R10");
      // R11: unmask one bit, irq follows in same cycle
      s_mask = 8'hF7; tick("R11"); quiet(1, "R11");
      s_mask = 8'h01; tick("R13"); quiet(1, "R13");
      do_read("R11"); quiet(1, "R11");
      s_mask = 8'h00; s_vis = 0; s_short = 0; tick("R4"); do_read("R4");

      // R12 underrun flag
      s_und = 1; tick("R12"); s_und = 0;
      quiet(4, "R12");
      do_read("R12"); quiet(2, "R12");
      s_und = 1; tick("R12"); s_und = 0;
      s_und = 1; s_rd = 1; tick("R12"); s_und = 0; s_rd = 0;
      quiet(2, "R12"); do_read("R12"); quiet(1, "R12");

      // random mix
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 9) == 0) s_lof   = ~s_lof;
         if ($urandom_range(0, 9) == 0) s_lomf  = ~s_lomf;
         if ($urandom_range(0, 9) == 0) s_open  = ~s_open;
         if ($urandom_range(0, 9) == 0) s_short = ~s_short;
         if ($urandom_range(0, 11) == 0) s_alm  = ~s_alm;
         s_mf  = ($urandom_range(0, 4) == 0);
         s_pr  = ($urandom_range(0, 4) == 0);
         s_und = ($urandom_range(0, 19) == 0);
         s_rd  = ($urandom_range(0, 6) == 0);
         if ($urandom_range(0, 15) == 0) s_mask = 8'($urandom);
         if ($urandom_range(0, 31) == 0) s_vis = ~s_vis;
         tick("R2");
      end
      quiet(2, "R2");
      finish_run();
   end
endmodule